// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host port that writes one 32-bit dword per cycle and a set of wider internal targets. It turns sequences of dword writes into single full-width commits. 128-bit control registers and 64-bit memory words are gathered in one shared collector. Each commits only once every dword of that target has arrived. Plain 32-bit registers pass straight through.

Descriptor-pointer registers get special handling. They are write-only 128-bit registers. Writing the top dword of one always commits it, and any low dwords that were not gathered are filled with zero. A low-dword write to such a register is dropped while the collector is busy with a different target. A write to the timer-command register on page 0 empties the collector.

Per-queue registers repeat on pages 0x2000 bytes apart. The byte address of a register is page × 0x2000 + offset. Each commit appears on the output as a one-cycle strobe carrying the target base address, a size code and the full-width data.

Top module: `wide_write_collector`

## Requirements
- R1: A write to a plain register commits one cycle later with size code 0. The commit address is the dword address, the data sits in bits 31:0, and bits 127:32 are zero. Plain registers are offsets 0x400–0xFFF of a page, other than the two descriptor blocks.
- R2: A 128-bit register (offsets 0x000–0x3FF) commits only once all four of its dwords have been written for the same base, in any order. The commit comes one cycle after the last dword, with size code 2, the 16-byte-aligned base address, and dword k (address base+4k) in bits 32k+31:32k.
- R3: A 64-bit memory word (offsets 0x1000–0x1FFF) commits after both of its dwords have arrived, with size code 1 and the 8-byte-aligned base. Its bits 127:64 are zero.
- R4: A 128-bit or 64-bit write whose base differs from the target being collected discards the partial collection and starts a new one from that write.
- R5: A write to the top dword (base+12) of a descriptor block commits the 128-bit register one cycle later, with size code 2. The low 96 bits carry the collected dwords if all three were gathered for that same base; otherwise they are zero. The collector is empty afterwards.
- R6: A low-dword write to a descriptor block is discarded, leaving the collector unchanged, while the collector holds data for a different base.
- R7: A low-dword write to a descriptor block never produces a commit.
- R8: The descriptor blocks sit at offsets 0x830 and 0xA10 of every page. Collections on different pages are different targets.
- R9: A write to the timer-command register (offset 0x420) commits as a plain dword. On page 0 it also empties the collector; on any other page the collector is kept.
- R10: After any commit of a collected target the collector is empty, so rewriting fewer than all dwords of that target does not commit.
- R11: The commit strobe is low during and after reset until a triggering write, and is never high in a cycle that follows a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host dword write strobe |
| wr_addr | input | ADDR_W (15) | Byte address of the dword, page in the upper bits |
| wr_data | input | DW (32) | Dword write data |
| cmt_valid | output | 1 | One-cycle commit strobe |
| cmt_size | output | 2 | Commit size: 0 dword, 1 64-bit, 2 128-bit |
| cmt_addr | output | ADDR_W (15) | Base byte address of the committed target |
| cmt_data | output | 4*DW (128) | Full-width commit data |

## Verification
The assertions watch every cycle for the behaviours that depend only on the current write:
- plain writes committing at once with zero upper bits;
- descriptor top dwords committing with their own data in the upper lane;
- descriptor low dwords staying silent;
- commits never appearing without a write;
- alignment and zero upper half for the wider sizes.

Everything that rests on what the collector holds needs the bench's ordered write sequences. That covers completion in any dword order, restarts on a new base, dropping of stray descriptor dwords, zero-fill against partial collections, clearing by the page-0 timer command and emptiness after a commit.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int OW_LANES = 4;
  localparam int QW_LANES = 2;

  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_QWORD = 2'd1,
    K_OWORD = 2'd2,
    K_DESC  = 2'd3
  } wkind_e;

  localparam logic [1:0] SZ_DWORD = 2'd0;
  localparam logic [1:0] SZ_QWORD = 2'd1;
  localparam logic [1:0] SZ_OWORD = 2'd2;
endpackage

// File: rtl/wc_decode.sv
module wc_decode
  import wc_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_SHIFT = 13,
  parameter int WIDE_LIMIT = 'h400,
  parameter int MEM_START  = 'h1000,
  parameter int DESC_A     = 'h830,
  parameter int DESC_B     = 'ha10,
  parameter int TIMER_OFS  = 'h420
) (
  input  logic [ADDR_W-1:0] addr,
  output wkind_e            kind,
  output logic [ADDR_W-1:0] base,
  output logic [1:0]        lane,
  output logic              clr
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam logic [PAGE_SHIFT-1:0] WL = PAGE_SHIFT'(WIDE_LIMIT);
  localparam logic [PAGE_SHIFT-1:0] MS = PAGE_SHIFT'(MEM_START);
  localparam logic [PAGE_SHIFT-1:0] DA = PAGE_SHIFT'(DESC_A);
  localparam logic [PAGE_SHIFT-1:0] DB = PAGE_SHIFT'(DESC_B);
  localparam logic [PAGE_SHIFT-1:0] TO = PAGE_SHIFT'(TIMER_OFS);

  logic [PAGE_SHIFT-1:0] off;
  logic [PAGE_W-1:0]     page;
  logic                  is_desc;

  assign off  = addr[PAGE_SHIFT-1:0];
  assign page = addr[ADDR_W-1:PAGE_SHIFT];

  assign is_desc = (off[PAGE_SHIFT-1:4] == DA[PAGE_SHIFT-1:4]) ||
                   (off[PAGE_SHIFT-1:4] == DB[PAGE_SHIFT-1:4]);

  always_comb begin
    if (is_desc)        kind = K_DESC;
    else if (off < WL)  kind = K_OWORD;
    else if (off >= MS) kind = K_QWORD;
    else                kind = K_PLAIN;
  end

  always_comb begin
    unique case (kind)
      K_QWORD: begin
        base = {addr[ADDR_W-1:3], 3'b000};
        lane = {1'b0, addr[2]};
      end
      K_PLAIN: begin
        base = {addr[ADDR_W-1:2], 2'b00};
        lane = addr[3:2];
      end
      default: begin
        base = {addr[ADDR_W-1:4], 4'b0000};
        lane = addr[3:2];
      end
    endcase
  end

  assign clr = (off == TO) && (page == '0);
endmodule

// File: rtl/wc_gather.sv
module wc_gather
  import wc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  wkind_e                 kind,
  input  logic [ADDR_W-1:0]      base,
  input  logic [1:0]             lane,
  input  logic                   clr,
  input  logic [DW-1:0]          wdata,
  output logic                   req,
  output logic [1:0]             req_size,
  output logic [ADDR_W-1:0]      req_addr,
  output logic [OW_LANES*DW-1:0] req_data
);
  localparam int WIDE_W = OW_LANES * DW;

  logic [OW_LANES-1:0]         mask_q, mask_d;
  logic [ADDR_W-1:0]           base_q;
  logic [OW_LANES-1:0][DW-1:0] lane_q;
  logic [OW_LANES-1:0][DW-1:0] merged;
  logic [OW_LANES-1:0]         onehot, acc, ld_en;
  logic                        hit, full, store, base_en;

  assign onehot = OW_LANES'(1) << lane;
  assign hit    = (mask_q != '0) && (base_q == base);
  assign acc    = (hit ? mask_q : '0) | onehot;
  assign full   = (kind == K_OWORD) ? (&acc) : (&acc[QW_LANES-1:0]);

  for (genvar i = 0; i < OW_LANES; i++) begin : g_lane
    assign merged[i] = (lane == 2'(i)) ? wdata : lane_q[i];
    assign ld_en[i]  = store && (lane == 2'(i));
  end

  always_comb begin
    mask_d   = mask_q;
    store    = 1'b0;
    base_en  = 1'b0;
    req      = 1'b0;
    req_size = SZ_DWORD;
    req_addr = base;
    req_data = '0;
    if (we) begin
      unique case (kind)
        K_PLAIN: begin
          req           = 1'b1;
          req_data[DW-1:0] = wdata;
          if (clr) mask_d = '0;
        end
        K_OWORD, K_QWORD: begin
          if (full) begin
            req    = 1'b1;
            mask_d = '0;
            if (kind == K_OWORD) begin
              req_size = SZ_OWORD;
              req_data = merged;
            end else begin
              req_size = SZ_QWORD;
              req_data[QW_LANES*DW-1:0] = merged[QW_LANES-1:0];
            end
          end else begin
            mask_d  = acc;
            store   = 1'b1;
            base_en = 1'b1;
          end
        end
        default: begin
          if (lane == 2'(OW_LANES-1)) begin
            req      = 1'b1;
            req_size = SZ_OWORD;
            mask_d   = '0;
            if (hit && (&mask_q[OW_LANES-2:0])) req_data = merged;
            else req_data[WIDE_W-1 -: DW] = wdata;
          end else if (mask_q == '0 || hit) begin
            mask_d  = acc;
            store   = 1'b1;
            base_en = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (base_en) base_q <= base;
  end

  for (genvar i = 0; i < OW_LANES; i++) begin : g_store
    always_ff @(posedge clk) begin
      if (ld_en[i]) lane_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/wc_commit_out.sv
module wc_commit_out
  import wc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic [1:0]             req_size,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [OW_LANES*DW-1:0] req_data,
  output logic                   cmt_valid,
  output logic [1:0]             cmt_size,
  output logic [ADDR_W-1:0]      cmt_addr,
  output logic [OW_LANES*DW-1:0] cmt_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmt_valid <= 1'b0;
    else        cmt_valid <= req;
  end

  always_ff @(posedge clk) begin
    if (req) begin
      cmt_size <= req_size;
      cmt_addr <= req_addr;
      cmt_data <= req_data;
    end
  end
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import wc_pkg::*;
#(
  parameter int PAGE_SHIFT = 13,
  parameter int PAGE_BITS  = 2,
  parameter int ADDR_W     = PAGE_SHIFT + PAGE_BITS,
  parameter int DW         = 32,
  parameter int WIDE_LIMIT = 'h400,
  parameter int MEM_START  = 'h1000,
  parameter int DESC_A     = 'h830,
  parameter int DESC_B     = 'ha10,
  parameter int TIMER_OFS  = 'h420
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DW-1:0]          wr_data,
  output logic                   cmt_valid,
  output logic [1:0]             cmt_size,
  output logic [ADDR_W-1:0]      cmt_addr,
  output logic [OW_LANES*DW-1:0] cmt_data
);
  logic [1:0]             rst_pipe;
  logic                   rst_sync_n;
  wkind_e                 d_kind;
  logic [ADDR_W-1:0]      d_base;
  logic [1:0]             d_lane;
  logic                   d_clr;
  logic                   g_req;
  logic [1:0]             g_size;
  logic [ADDR_W-1:0]      g_addr;
  logic [OW_LANES*DW-1:0] g_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  wc_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .WIDE_LIMIT(WIDE_LIMIT),
    .MEM_START(MEM_START), .DESC_A(DESC_A), .DESC_B(DESC_B), .TIMER_OFS(TIMER_OFS)
  ) u_decode (
    .addr(wr_addr), .kind(d_kind), .base(d_base), .lane(d_lane), .clr(d_clr)
  );

  wc_gather #(.ADDR_W(ADDR_W), .DW(DW)) u_gather (
    .clk(clk), .rst_n(rst_sync_n), .we(wr_en), .kind(d_kind), .base(d_base),
    .lane(d_lane), .clr(d_clr), .wdata(wr_data),
    .req(g_req), .req_size(g_size), .req_addr(g_addr), .req_data(g_data)
  );

  wc_commit_out #(.ADDR_W(ADDR_W), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .req(g_req), .req_size(g_size),
    .req_addr(g_addr), .req_data(g_data),
    .cmt_valid(cmt_valid), .cmt_size(cmt_size), .cmt_addr(cmt_addr), .cmt_data(cmt_data)
  );
endmodule

// File: rtl/wc_collector_chk.sv
module wc_collector_chk #(
  parameter int PAGE_SHIFT = 13,
  parameter int ADDR_W     = 15,
  parameter int DW         = 32,
  parameter int WIDE_LIMIT = 'h400,
  parameter int MEM_START  = 'h1000,
  parameter int DESC_A     = 'h830,
  parameter int DESC_B     = 'ha10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              cmt_valid,
  input logic [1:0]        cmt_size,
  input logic [ADDR_W-1:0] cmt_addr,
  input logic [4*DW-1:0]   cmt_data
);
  int  off;
  logic in_desc, in_plain, top_dw;
  logic [ADDR_W-1:0] blk_base;

  assign off      = int'(wr_addr) % (1 << PAGE_SHIFT);
  assign in_desc  = ((off - DESC_A) >= 0 && (off - DESC_A) < 16) ||
                    ((off - DESC_B) >= 0 && (off - DESC_B) < 16);
  assign in_plain = !in_desc && off >= WIDE_LIMIT && off < MEM_START;
  assign top_dw   = (wr_addr[3:2] == 2'b11);
  assign blk_base = wr_addr & ~ADDR_W'(15);

  a_r1_plain_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && in_plain |=> cmt_valid && cmt_size == 2'd0 &&
    cmt_data[DW-1:0] == $past(wr_data) && cmt_data[4*DW-1:DW] == '0);

  a_r5_desc_top_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && in_desc && top_dw |=> cmt_valid && cmt_size == 2'd2 &&
    cmt_addr == $past(blk_base) && cmt_data[4*DW-1:3*DW] == $past(wr_data));

  a_r7_desc_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && in_desc && !top_dw |=> !cmt_valid);

  a_r11_no_write_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !cmt_valid);

  a_r3_qword_shape: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && cmt_size == 2'd1 |-> cmt_data[4*DW-1:2*DW] == '0 && cmt_addr[2:0] == 3'b000);

  a_r2_oword_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && cmt_size == 2'd2 |-> cmt_addr[3:0] == 4'b0000);
endmodule

bind wide_write_collector wc_collector_chk #(
  .PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W), .DW(DW), .WIDE_LIMIT(WIDE_LIMIT),
  .MEM_START(MEM_START), .DESC_A(DESC_A), .DESC_B(DESC_B)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cmt_valid(cmt_valid), .cmt_size(cmt_size), .cmt_addr(cmt_addr), .cmt_data(cmt_data)
);

// File: tb/test_wide_write_collector.sv
module test_wide_write_collector;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [14:0]  wr_addr;
  logic [31:0]  wr_data;
  logic         cmt_valid;
  logic [1:0]   cmt_size;
  logic [14:0]  cmt_addr;
  logic [127:0] cmt_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R11";

  // model state
  bit          m_have [4];
  logic [31:0] m_val  [4];
  int          m_base = -1;
  logic         e_v;
  logic [1:0]   e_sz;
  logic [14:0]  e_a;
  logic [127:0] e_d;

  always #2 clk = ~clk;   // 250 MHz

  wide_write_collector i_wide_write_collector (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmt_valid(cmt_valid), .cmt_size(cmt_size), .cmt_addr(cmt_addr), .cmt_data(cmt_data)
  );

  function automatic bit m_busy();
    return m_have[0] | m_have[1] | m_have[2] | m_have[3];
  endfunction

  task automatic m_empty();
    for (int i = 0; i < 4; i++) m_have[i] = 0;
  endtask

  // Expected commit per requirements R1-R10 (offset decoding as stated there)
  task automatic model(input int a, input logic [31:0] d);
    int off, pg, ln, bs, need, cnt;
    bit desc;
    off  = a % 8192;
    pg   = a / 8192;
    desc = ((off & ~15) == 'h830) || ((off & ~15) == 'ha10);
    e_v = 0; e_sz = 0; e_a = 0; e_d = 0;
    if (desc) begin
      bs = a & ~15; ln = (a / 4) % 4;
      if (ln == 3) begin
        e_v = 1; e_sz = 2; e_a = 15'(bs);
        e_d[127:96] = d;
        if (m_busy() && m_base == bs && m_have[0] && m_have[1] && m_have[2])
          e_d[95:0] = {m_val[2], m_val[1], m_val[0]};
        m_empty();
      end else if (!(m_busy() && m_base != bs)) begin
        if (!m_busy()) m_empty();
        m_base = bs; m_have[ln] = 1; m_val[ln] = d;
      end
    end else if (off < 'h400 || off >= 'h1000) begin
      need = (off < 'h400) ? 4 : 2;
      bs   = (need == 4) ? (a & ~15) : (a & ~7);
      ln   = (need == 4) ? (a / 4) % 4 : (a / 4) % 2;
      if (!m_busy() || m_base != bs) begin m_empty(); m_base = bs; end
      m_have[ln] = 1; m_val[ln] = d;
      cnt = 0;
      for (int i = 0; i < 4; i++) cnt += int'(m_have[i]);
      if (cnt == need) begin
        e_v = 1; e_sz = (need == 4) ? 2'd2 : 2'd1; e_a = 15'(bs);
        for (int i = 0; i < need; i++) e_d[32*i +: 32] = m_val[i];
        m_empty();
      end
    end else begin
      e_v = 1; e_sz = 0; e_a = 15'(a & ~3); e_d[31:0] = d;
      if (off == 'h420 && pg == 0) m_empty();
    end
  endtask

  task automatic check_out();
    checks++;
    if (cmt_valid !== e_v || (e_v && (cmt_size !== e_sz || cmt_addr !== e_a || cmt_data !== e_d))) begin
      fails++;
      $display("FAIL %s: got v=%0b sz=%0d a=%h d=%h expected v=%0b sz=%0d a=%h d=%h",
               cur_req, cmt_valid, cmt_size, cmt_addr, cmt_data, e_v, e_sz, e_a, e_d);
    end
  endtask

  // called at a falling edge; checks the commit at the following falling edge
  task automatic wr(input int a, input logic [31:0] d);
    model(a, d);
    wr_en = 1'b1; wr_addr = 15'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check_out();
  endtask

  task automatic idle_check();
    e_v = 0;
    @(negedge clk);
    check_out();
  endtask

  function automatic logic [31:0] dat(input int s);
    return 32'(s) * 32'h9E37_79B9 + 32'h0BAD_F00D;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11: watchdog expired, got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int p, n;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    m_empty();
    repeat (3) @(negedge clk);
    cur_req = "R11"; e_v = 0; check_out();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check();

    // R1: plain dwords across pages; R9 timer on pages other than 0
    cur_req = "R1";
    n = 0;
    for (int pg = 0; pg < 4; pg++) begin
      wr(pg * 8192 + 'h400, dat(n++));
      wr(pg * 8192 + 'h7fc, dat(n++));
      wr(pg * 8192 + 'hffc, dat(n++));
      if (pg != 0) wr(pg * 8192 + 'h420, dat(n++));
    end
    idle_check();

    // R2: every dword order of a 128-bit register
    cur_req = "R2";
    p = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              wr(16 * p + 4 * a, dat(100 + 4 * p + a));
              wr(16 * p + 4 * b, dat(100 + 4 * p + b));
              wr(16 * p + 4 * c, dat(100 + 4 * p + c));
              wr(16 * p + 4 * d, dat(100 + 4 * p + d));
              p++;
            end

    // R3: 64-bit memory words, both orders, several pages
    cur_req = "R3";
    for (int k = 0; k < 8; k++) begin
      int bq = (k % 4) * 8192 + 'h1000 + 8 * k * 37;
      if (k % 2 == 0) begin wr(bq, dat(300 + k)); wr(bq + 4, dat(400 + k)); end
      else begin wr(bq + 4, dat(400 + k)); wr(bq, dat(300 + k)); end
    end

    // R5 and R8: descriptor top commit with every subset of low dwords, every page, both blocks
    cur_req = "R5";
    for (int pg = 0; pg < 4; pg++)
      for (int blk = 0; blk < 2; blk++)
        for (int s = 0; s < 8; s++) begin
          int bd = pg * 8192 + (blk ? 'ha10 : 'h830);
          cur_req = (pg != 0) ? "R8" : "R5";
          for (int l = 0; l < 3; l++)
            if (s[l]) wr(bd + 4 * l, dat(500 + 32 * pg + 8 * s + l));
          cur_req = "R7"; idle_check();
          cur_req = (pg != 0) ? "R8" : "R5";
          wr(bd + 12, dat(900 + 16 * pg + s));
        end

    // R8: same descriptor offset on another page is a different target
    cur_req = "R8";
    wr('h830, dat(1000)); wr('h834, dat(1001)); wr('h838, dat(1002));
    wr(8192 + 'h83c, dat(1003));          // zero-filled, collector emptied
    wr('h83c, dat(1004));                 // collector empty now: zero-filled too

    // R4 and R10: restart on new base, emptiness after commit
    cur_req = "R4";
    wr('h100, dat(1100)); wr('h104, dat(1101));
    wr('h200, dat(1200)); wr('h204, dat(1201)); wr('h208, dat(1202)); wr('h20c, dat(1203));
    cur_req = "R10";
    wr('h208, dat(1210)); wr('h20c, dat(1211));
    cur_req = "R4";
    wr('h108, dat(1102)); wr('h10c, dat(1103));   // A restarted: no commit
    wr('h100, dat(1104)); wr('h104, dat(1105));   // completes A from fresh lanes
    wr('h1008, dat(1300)); wr('h1010, dat(1301)); wr('h100c, dat(1302)); wr('h1014, dat(1303));

    // R6: stray descriptor low dwords dropped while collector busy elsewhere
    cur_req = "R6";
    wr('h020, dat(1400)); wr('h024, dat(1401));
    wr('h830, dat(1402)); wr('h834, dat(1403)); wr(8192 + 'ha18, dat(1404));
    wr('h028, dat(1405)); wr('h02c, dat(1406));   // original data intact
    wr(8192 + 'ha10, dat(1410)); wr(8192 + 'ha14, dat(1411));
    wr('hA14, dat(1412));                          // page 0 block B: dropped
    wr(8192 + 'ha18, dat(1413)); wr(8192 + 'ha1c, dat(1414));

    // R9: page-0 timer clears, other pages keep
    cur_req = "R9";
    wr('h030, dat(1500)); wr('h034, dat(1501)); wr('h038, dat(1502));
    wr('h420, dat(1503));
    wr('h03c, dat(1504));                           // no commit
    wr('h040, dat(1510)); wr('h044, dat(1511)); wr('h048, dat(1512));
    wr(3 * 8192 + 'h420, dat(1513));
    wr('h04c, dat(1514));                           // full commit
    wr('h1100, dat(1520)); wr('h420, dat(1521)); wr('h1104, dat(1522));
    wr('h1100, dat(1523)); wr('h1104, dat(1524));

    // R5/R10: descriptor top while collector holds another target
    cur_req = "R5";
    wr('h050, dat(1600)); wr('h054, dat(1601));
    wr('h83c, dat(1602));
    cur_req = "R10";
    wr('h058, dat(1603)); wr('h05c, dat(1604));   // emptied: no commit
    idle_check();

    done = 1;
    summary();
    $finish;
  end
endmodule